// File: doc/BRIEF.md
# Condition-Register Predication Execute Unit

This unit decodes and executes four related instructions. Each one tests condition bits against a 4-bit pattern under a 4-bit mask, for a 64-bit core with eight 4-bit condition-register (CR) fields. Each mask lane i gives a bit n[i] = mask[i] AND (mode[i] == source[i]). The source is either one CR field or the least significant bit of an integer register, copied to all four lanes.

The lane bits are then handled in one of two ways:
- **4-bit field write.** The four lane bits go as a group into a CR field.
- **Reduction.** The lane bits are reduced by AND or by OR. The result goes to the LSB of an integer register or to one addressed CR bit.

The integer-result form can also record a signed analysis of its result into CR field 0.

The unit takes the instruction word, the integer source value, the whole CR and a summary-overflow flag. Its outputs are registered and show one clock after the inputs. They describe which writes the register files should perform: an integer write, a CR field write, a single CR bit write, and a match flag.

Bit positions follow MSB0 numbering: instruction bit k is `insn_i[31-k]`, and CR bit k is `cr_i[31-k]`. CR field f holds CR bits 4f..4f+3. In every 4-bit vector here, vector bit 3 is lane 0 (the lowest MSB0 position).

Top module: `crpred_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to zero after that edge. Otherwise each output reflects the inputs sampled at the previous rising edge.
- R2: `match_o` is 1 only when bits 0-5 equal 19, bits 21-25 equal the parameter `XO_CODE` and bit 26 is 0. When `match_o` is 0, all three write enables are 0.
- R3: Instruction bits 11 and 19 pick the variant: 00 integer result, 10 integer to field, 01 field to field, 11 field to single bit.
- R4: The lane bits use the mask from bits 12-15 and the mode from bits 27-30, lane 0 at the lowest bit number: n[i] = mask[i] AND (mode[i] == src[i]).
- R5: The integer-result form compares against CR field BB (bits 16-18). It writes the register numbered by bits 6-10 with bits 63..1 zero. Bit 0 is the OR of the lane bits when bit 20 is 1, and their AND when bit 20 is 0.
- R6: In the integer-result form with bit 31 set, CR field 0 is also written with {lt=0, gt=r, eq=~r, so=so_i}, where r is the written LSB. Without bit 31 set, there is no CR write.
- R7: The integer-to-field form reads the register numbered by bits 6-10, with register 0 read as zero. It compares every lane with that register's LSB and writes the lane vector into CR field bits 16-18.
- R8: The field-to-field form compares against CR field bits 16-18 and writes the lane vector into the CR field named by bits 6-8.
- R9: The single-bit form compares against CR field bits 16-18. It writes only the bit-20-selected reduction into the CR bit numbered by bits 6-10.
- R10: At most one kind of write occurs per instruction. The only exception is the integer form with bit 31 set, which pairs its integer write with a CR field 0 write.
- R11: In the integer-to-field form with register 0, a mask of 1111 and an inverted mode, the field receives the un-inverted mode. With a mode of 0000, the field receives the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| ra_i | input | 64 | Value of the integer register named by bits 6-10 |
| cr_i | input | 32 | Whole condition register |
| so_i | input | 1 | Summary-overflow flag for the record analysis |
| match_o | output | 1 | Instruction belongs to this unit |
| int_we_o | output | 1 | Integer register write enable |
| int_dst_o | output | 5 | Integer destination register number |
| int_data_o | output | 64 | Integer write data |
| crf_we_o | output | 1 | CR field write enable |
| crf_sel_o | output | 3 | CR field number |
| crf_data_o | output | 4 | CR field data, bit 3 is lane 0 |
| crb_we_o | output | 1 | Single CR bit write enable |
| crb_sel_o | output | 5 | CR bit number, MSB0 |
| crb_data_o | output | 1 | CR bit data |

## Verification
Some properties are checked by the assertions on every cycle:
- the reset state;
- no enables without a decode match;
- a non-19 opcode never matching;
- the zero upper bits of the integer result;
- the single-bit write excluding the other writes;
- CR0 record data agreeing with the integer LSB.

Other behaviour only shows in the bench's scenarios against a reference model:
- that the right CR field is read;
- the lane ordering of mask and mode;
- the choice between AND and OR reduction;
- that register 0 reads as zero;
- the two load idioms.

// File: rtl/crpred_pkg.sv
// Package: shared types and fixed instruction field positions (MSB0).
// Assumes a 32-bit instruction word; bit k MSB0 is insn[31-k].
package crpred_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [1:0] {
        VAR_TO_INT   = 2'b00,
        VAR_CR_TO_CR = 2'b01,
        VAR_FROM_INT = 2'b10,
        VAR_TO_BIT   = 2'b11
    } variant_e;

    typedef struct packed {
        logic       hit;
        variant_e   variant;
        logic [3:0] mask;
        logic [3:0] mode;
        logic       use_or;
        logic       rec;
        logic [2:0] fld_b;
        logic [4:0] reg_a;
        logic [2:0] fld_d;
    } dec_t;

endpackage

// File: rtl/crpred_decode.sv
// Module: instruction field extraction and match detection.
// Assumes MSB0 numbering; vector bit 3 of mask/mode is lane 0.
module crpred_decode
    import crpred_pkg::*;
#(
    parameter logic [4:0] XO_CODE = 5'd12,
    parameter logic [5:0] PRIMARY = 6'd19
) (
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    // Slice fixed positions into the decoded record.
    always_comb begin
        dec.hit     = (insn[31:26] == PRIMARY) && (insn[10:6] == XO_CODE) && !insn[5];
        dec.variant = variant_e'({insn[20], insn[12]});
        dec.mask    = insn[19:16];
        dec.mode    = insn[4:1];
        dec.use_or  = insn[11];
        dec.rec     = insn[0];
        dec.fld_b   = insn[15:13];
        dec.reg_a   = insn[25:21];
        dec.fld_d   = insn[25:23];
    end
endmodule

// File: rtl/crpred_lanes.sv
// Module: masked per-lane comparison and AND/OR reduction.
// Assumes all vectors share the same lane ordering.
module crpred_lanes #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] mask,
    input  logic [LANES-1:0] mode,
    input  logic [LANES-1:0] src,
    input  logic             use_or,
    output logic [LANES-1:0] lanes,
    output logic             reduced
);
    // One comparator per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = mask[g] & ~(mode[g] ^ src[g]);
    end

    // Select OR or AND reduction of the lane bits.
    always_comb reduced = use_or ? |lanes : &lanes;
endmodule

// File: rtl/crpred_wb.sv
// Module: forms the write requests from the decoded variant.
// Assumes lanes/reduced come from the source selected for that variant.
module crpred_wb
    import crpred_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int FIELD_W = 4,
    parameter int FSEL_W  = 3,
    parameter int BSEL_W  = 5
) (
    input  dec_t               dec,
    input  logic [FIELD_W-1:0] lanes,
    input  logic               reduced,
    input  logic               so,
    output logic               int_we,
    output logic [4:0]         int_dst,
    output logic [XLEN-1:0]    int_data,
    output logic               crf_we,
    output logic [FSEL_W-1:0]  crf_sel,
    output logic [FIELD_W-1:0] crf_data,
    output logic               crb_we,
    output logic [BSEL_W-1:0]  crb_sel,
    output logic               crb_data
);
    // Route results to the destination chosen by the variant.
    always_comb begin
        int_we   = 1'b0;
        int_dst  = '0;
        int_data = '0;
        crf_we   = 1'b0;
        crf_sel  = '0;
        crf_data = '0;
        crb_we   = 1'b0;
        crb_sel  = '0;
        crb_data = 1'b0;
        if (dec.hit) begin
            unique case (dec.variant)
                VAR_TO_INT: begin
                    int_we   = 1'b1;
                    int_dst  = dec.reg_a;
                    int_data = {{(XLEN-1){1'b0}}, reduced};
                    if (dec.rec) begin
                        crf_we   = 1'b1;
                        crf_sel  = '0;
                        crf_data = {1'b0, reduced, ~reduced, so};
                    end
                end
                VAR_FROM_INT: begin
                    crf_we   = 1'b1;
                    crf_sel  = dec.fld_b;
                    crf_data = lanes;
                end
                VAR_CR_TO_CR: begin
                    crf_we   = 1'b1;
                    crf_sel  = dec.fld_d;
                    crf_data = lanes;
                end
                VAR_TO_BIT: begin
                    crb_we   = 1'b1;
                    crb_sel  = dec.reg_a;
                    crb_data = reduced;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crpred_unit.sv
// Module: top of the CR predication execute unit.
// Selects the compare source, then registers the write requests.
// Assumes synchronous active-low reset and one-cycle latency.
module crpred_unit
    import crpred_pkg::*;
#(
    parameter int         XLEN       = 64,
    parameter int         NUM_FIELDS = 8,
    parameter int         FIELD_W    = 4,
    parameter logic [4:0] XO_CODE    = 5'd12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [31:0]                       insn_i,
    input  logic [XLEN-1:0]                   ra_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0]     cr_i,
    input  logic                              so_i,
    output logic                              match_o,
    output logic                              int_we_o,
    output logic [4:0]                        int_dst_o,
    output logic [XLEN-1:0]                   int_data_o,
    output logic                              crf_we_o,
    output logic [$clog2(NUM_FIELDS)-1:0]     crf_sel_o,
    output logic [FIELD_W-1:0]                crf_data_o,
    output logic                              crb_we_o,
    output logic [$clog2(NUM_FIELDS*FIELD_W)-1:0] crb_sel_o,
    output logic                              crb_data_o
);
    localparam int CR_W   = NUM_FIELDS * FIELD_W;
    localparam int FSEL_W = $clog2(NUM_FIELDS);
    localparam int BSEL_W = $clog2(CR_W);

    dec_t               dec;
    logic [FIELD_W-1:0] fld [NUM_FIELDS];
    logic [FIELD_W-1:0] src;
    logic               ra_lsb;
    logic [FIELD_W-1:0] lanes;
    logic               reduced;
    logic               unused_ra;

    logic               n_int_we, n_crf_we, n_crb_we, n_crb_data;
    logic [4:0]         n_int_dst;
    logic [XLEN-1:0]    n_int_data;
    logic [FSEL_W-1:0]  n_crf_sel;
    logic [FIELD_W-1:0] n_crf_data;
    logic [BSEL_W-1:0]  n_crb_sel;

    crpred_decode #(.XO_CODE(XO_CODE)) u_dec (.insn(insn_i), .dec(dec));

    // Split the CR into fields, field 0 at the most significant end.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        assign fld[g] = cr_i[CR_W-1-FIELD_W*g -: FIELD_W];
    end

    assign unused_ra = ^ra_i[XLEN-1:1];

    // Register 0 reads as zero; pick integer LSB or CR field as the source.
    always_comb begin
        ra_lsb = (dec.reg_a == 5'd0) ? 1'b0 : ra_i[0];
        src    = (dec.variant == VAR_FROM_INT) ? {FIELD_W{ra_lsb}} : fld[dec.fld_b];
    end

    crpred_lanes #(.LANES(FIELD_W)) u_lanes (
        .mask(dec.mask), .mode(dec.mode), .src(src), .use_or(dec.use_or),
        .lanes(lanes), .reduced(reduced)
    );

    crpred_wb #(.XLEN(XLEN), .FIELD_W(FIELD_W), .FSEL_W(FSEL_W), .BSEL_W(BSEL_W)) u_wb (
        .dec(dec), .lanes(lanes), .reduced(reduced), .so(so_i),
        .int_we(n_int_we), .int_dst(n_int_dst), .int_data(n_int_data),
        .crf_we(n_crf_we), .crf_sel(n_crf_sel), .crf_data(n_crf_data),
        .crb_we(n_crb_we), .crb_sel(n_crb_sel), .crb_data(n_crb_data)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o    <= 1'b0;
            int_we_o   <= 1'b0;
            int_dst_o  <= '0;
            int_data_o <= '0;
            crf_we_o   <= 1'b0;
            crf_sel_o  <= '0;
            crf_data_o <= '0;
            crb_we_o   <= 1'b0;
            crb_sel_o  <= '0;
            crb_data_o <= 1'b0;
        end else begin
            match_o    <= dec.hit;
            int_we_o   <= n_int_we;
            int_dst_o  <= n_int_dst;
            int_data_o <= n_int_data;
            crf_we_o   <= n_crf_we;
            crf_sel_o  <= n_crf_sel;
            crf_data_o <= n_crf_data;
            crb_we_o   <= n_crb_we;
            crb_sel_o  <= n_crb_sel;
            crb_data_o <= n_crb_data;
        end
    end
endmodule

// File: rtl/crpred_unit_chk.sv
// Module: property checker bound to crpred_unit.
module crpred_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     insn_i,
    input logic            so_i,
    input logic            match_o,
    input logic            int_we_o,
    input logic [XLEN-1:0] int_data_o,
    input logic            crf_we_o,
    input logic [2:0]      crf_sel_o,
    input logic [3:0]      crf_data_o,
    input logic            crb_we_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!match_o && !int_we_o && !crf_we_o && !crb_we_o));

    // R2
    no_match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (!int_we_o && !crf_we_o && !crb_we_o));

    // R2
    opcode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[31:26] != 6'd19) |=> !match_o);

    // R5
    int_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_we_o |-> (int_data_o[XLEN-1:1] == '0));

    // R10
    bit_write_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crb_we_o |-> (!int_we_o && !crf_we_o));

    // R6
    record_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we_o && crf_we_o) |-> (crf_sel_o == 3'd0 && crf_data_o[3] == 1'b0
            && crf_data_o[2] == int_data_o[0] && crf_data_o[1] == !int_data_o[0]
            && crf_data_o[0] == $past(so_i)));
endmodule

bind crpred_unit crpred_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .so_i(so_i),
    .match_o(match_o), .int_we_o(int_we_o), .int_data_o(int_data_o),
    .crf_we_o(crf_we_o), .crf_sel_o(crf_sel_o), .crf_data_o(crf_data_o),
    .crb_we_o(crb_we_o)
);

// File: tb/crpred_unit_test.sv
`timescale 1ns/1ps
module crpred_unit_test;
    localparam logic [4:0] XO = 5'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] ra_i = '0;
    logic [31:0] cr_i = '0;
    logic        so_i = 1'b0;
    logic        match_o, int_we_o, crf_we_o, crb_we_o, crb_data_o;
    logic [4:0]  int_dst_o, crb_sel_o;
    logic [63:0] int_data_o;
    logic [2:0]  crf_sel_o;
    logic [3:0]  crf_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    crpred_unit #(.XO_CODE(XO)) uut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .ra_i(ra_i), .cr_i(cr_i),
        .so_i(so_i), .match_o(match_o), .int_we_o(int_we_o), .int_dst_o(int_dst_o),
        .int_data_o(int_data_o), .crf_we_o(crf_we_o), .crf_sel_o(crf_sel_o),
        .crf_data_o(crf_data_o), .crb_we_o(crb_we_o), .crb_sel_o(crb_sel_o),
        .crb_data_o(crb_data_o)
    );

    always #2.5 clk = ~clk;

    // expected values
    logic        e_match, e_iwe, e_fwe, e_bwe, e_bdat;
    logic [4:0]  e_idst, e_bsel;
    logic [63:0] e_idat;
    logic [2:0]  e_fsel;
    logic [3:0]  e_fdat;

    function automatic logic ib(input logic [31:0] w, input int k);
        return w[31-k];
    endfunction

    function automatic int ifield(input logic [31:0] w, input int s, input int n);
        int v = 0;
        for (int k = 0; k < n; k++) v = (v << 1) | int'(w[31-s-k]);
        return v;
    endfunction

    task automatic model(input logic [31:0] w, input logic [63:0] ra,
                         input logic [31:0] cr, input logic so);
        logic [3:0] nl;
        logic       srcb, red, m;
        int bb, ra_n;
        e_match = 0; e_iwe = 0; e_fwe = 0; e_bwe = 0; e_bdat = 0;
        e_idst = 0; e_bsel = 0; e_idat = 0; e_fsel = 0; e_fdat = 0;
        e_match = (ifield(w, 0, 6) == 19) && (ifield(w, 21, 5) == int'(XO)) && !ib(w, 26);
        bb   = ifield(w, 16, 3);
        ra_n = ifield(w, 6, 5);
        m    = ib(w, 20);
        for (int i = 0; i < 4; i++) begin
            if (ib(w, 11) && !ib(w, 19))
                srcb = (ra_n == 0) ? 1'b0 : ra[0];
            else
                srcb = cr[31 - (4*bb + i)];
            nl[3-i] = ib(w, 12+i) & (ib(w, 27+i) == srcb);
        end
        red = m ? (nl != 0) : (nl == 4'hF);
        if (e_match) begin
            case ({ib(w, 11), ib(w, 19)})
                2'b00: begin
                    e_iwe = 1; e_idst = 5'(ra_n); e_idat = {63'd0, red};
                    if (ib(w, 31)) begin e_fwe = 1; e_fsel = 0; e_fdat = {1'b0, red, ~red, so}; end
                end
                2'b10: begin e_fwe = 1; e_fsel = 3'(bb); e_fdat = nl; end
                2'b01: begin e_fwe = 1; e_fsel = 3'(ifield(w, 6, 3)); e_fdat = nl; end
                default: begin e_bwe = 1; e_bsel = 5'(ra_n); e_bdat = red; end
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input logic [63:0] ra,
                       input logic [31:0] cr, input logic so, input string tag);
        @(negedge clk);
        insn_i = w; ra_i = ra; cr_i = cr; so_i = so;
        model(w, ra, cr, so);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 match"}, 64'(match_o), 64'(e_match));
        chk({tag, " R3 int_we"}, 64'(int_we_o), 64'(e_iwe));
        chk({tag, " R10 crf_we"}, 64'(crf_we_o), 64'(e_fwe));
        chk({tag, " R10 crb_we"}, 64'(crb_we_o), 64'(e_bwe));
        if (e_iwe) begin
            chk({tag, " R5 int_dst"}, 64'(int_dst_o), 64'(e_idst));
            chk({tag, " R5 int_data"}, int_data_o, e_idat);
        end
        if (e_fwe) begin
            chk({tag, " R4 R6 R7 R8 crf_sel"}, 64'(crf_sel_o), 64'(e_fsel));
            chk({tag, " R4 R6 R7 R8 crf_data"}, 64'(crf_data_o), 64'(e_fdat));
        end
        if (e_bwe) begin
            chk({tag, " R9 crb_sel"}, 64'(crb_sel_o), 64'(e_bsel));
            chk({tag, " R9 crb_data"}, 64'(crb_data_o), 64'(e_bdat));
        end
    endtask

    // Build an instruction from its MSB0 fields.
    function automatic logic [31:0] mk(input int op, input int a, input bit b11, input int msk,
                                       input int bb, input bit b19, input bit b20,
                                       input int xo, input bit b26, input int mode, input bit rc);
        return {6'(op), 5'(a), b11, 4'(msk), 3'(bb), b19, b20, 5'(xo), b26, 4'(mode), rc};
    endfunction

    initial begin
        logic [31:0] w;
        // R1: reset state
        rst_n = 1'b0;
        insn_i = mk(19, 3, 0, 15, 1, 0, 1, XO, 0, 5, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset match", 64'(match_o), 0);
        chk("R1 reset enables", 64'({int_we_o, crf_we_o, crb_we_o}), 0);
        rst_n = 1'b1;

        // R11 idioms
        run(mk(19, 0, 1, 15, 5, 0, 0, XO, 0, 4'b0101, 0), 64'hFFFF, 32'h0, 0, "R11 mode load");
        chk("R11 field=mode", 64'(crf_data_o), 64'(4'b1010));
        run(mk(19, 0, 1, 4'b1001, 2, 0, 0, XO, 0, 0, 0), 64'h1, 32'hFFFF_FFFF, 0, "R11 mask load");
        chk("R11 field=mask", 64'(crf_data_o), 64'(4'b1001));
        // R7: nonzero register LSB used
        run(mk(19, 7, 1, 15, 3, 0, 0, XO, 0, 4'b0011, 0), 64'h1, 32'h0, 0, "R7 ra lsb");
        // R5/R6: integer form AND and OR, record
        run(mk(19, 9, 0, 15, 6, 0, 0, XO, 0, 4'b1100, 1), 64'h0, 32'h0000_00C0, 1, "R6 and rec");
        run(mk(19, 9, 0, 4'b0001, 6, 0, 1, XO, 0, 4'b0000, 1), 64'h0, 32'h0000_00C0, 0, "R5 or rec");
        run(mk(19, 9, 0, 0, 1, 0, 0, XO, 0, 0, 0), 64'h0, 32'h0, 0, "R5 empty mask and");
        // R8 / R9
        run(mk(19, 5 << 2, 0, 15, 7, 1, 0, XO, 0, 4'b1010, 0), 64'h0, 32'h1234_567A, 0, "R8 crcr");
        run(mk(19, 30, 1, 4'b0110, 4, 1, 1, XO, 0, 4'b0100, 0), 64'h0, 32'h0004_0000, 0, "R9 bit");
        // R2 mismatches
        run(mk(18, 3, 1, 15, 4, 1, 1, XO, 0, 0, 0), 64'h0, 32'h0, 0, "R2 bad opcode");
        run(mk(19, 3, 1, 15, 4, 1, 1, XO ^ 5'd1, 0, 0, 0), 64'h0, 32'h0, 0, "R2 bad xo");
        run(mk(19, 3, 1, 15, 4, 1, 1, XO, 1, 0, 0), 64'h0, 32'h0, 0, "R2 bit26");

        // Constrained random
        void'($urandom(32'd1357));
        for (int t = 0; t < 800; t++) begin
            w = $urandom;
            if ($urandom_range(99) < 85) begin w[31:26] = 6'd19; w[10:6] = XO; end
            if ($urandom_range(99) < 90) w[5] = 1'b0;
            run(w, {$urandom, $urandom}, $urandom, 1'($urandom), "R3 R4 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule